// File: doc/BRIEF.md
# Wiper Position Bank

This block keeps the tap position of several digitally controlled resistor ladders, one 6-bit code per ladder, and turns each code into a one-hot enable vector for the ladder's tap switches. Code 00h selects the tap at the low terminal and the highest code selects the tap at the high terminal. The positions are volatile. Whenever reset is asserted, each position is reloaded from the first stored setting of its own ladder, which a neighbouring non-volatile store presents on `nv_slot0`.

A position changes in one of four ways. A serial load writes a host-supplied code into one ladder. A single transfer copies one stored setting into one ladder. A global transfer copies a stored setting into every ladder in the same cycle. The fourth way is stepping. After the command decoder arms stepping for one ladder, every rising edge of the serial clock moves that ladder's code one tap up when the serial data line is high, or one tap down when it is low. Stepping goes on for any number of pulses and stops when chip select returns high. The serial clock, data and chip-select lines are resynchronised into the block clock domain. A readback port returns the code of any ladder for the serial output path.

Top module: `wiper_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every position is loaded from its own slice of `nv_slot0`: ladder p uses bits [p*6+5:p*6]. After reset this value is held until a load or step acts on it.
- R2: For each ladder p, `tap_sel[p*64 + k]` is 1 exactly when the code of ladder p equals k, and every other bit of that 64-bit slice is 0. Code 00h drives bit 0, the low terminal. Code 3Fh drives bit 63, the high terminal.
- R3: When `wr_en` is high at a clock edge, the code of ladder `wr_pot` becomes `wr_data` after that edge.
- R4: When `xfer_en` is high at a clock edge, the code of ladder `xfer_pot` becomes `xfer_data` after that edge.
- R5: When `gxfer_en` is high at a clock edge, every ladder p takes `gxfer_data[p*6+5:p*6]` after that edge.
- R6: When stepping is armed, a rising edge on `sck` moves the armed ladder's code one step up if `si` is 1, or one step down if `si` is 0. The new code appears SYNC_STAGES clock edges after the first edge that samples `sck` high. `si` is sampled with the same delay.
- R7: A pulse on `step_arm` arms stepping and latches `step_pot` as the ladder to step. Stepping continues for any number of `sck` pulses. It ends on a synchronised rising edge of `cs_n`. `sck` pulses while stepping is not armed change no code.
- R8: Stepping saturates. An up step at 3Fh leaves 3Fh, and a down step at 00h leaves 00h. A code never wraps.
- R9: When several sources act on one ladder at the same edge, one source wins in this order, highest first: serial load, global transfer, single transfer, step.
- R10: `rd_data` always equals the current code of ladder `rd_pot`, with no clock delay.
- R11: A step changes only the armed ladder. Every other ladder keeps its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; reloads the positions from `nv_slot0` |
| nv_slot0 | input | NPOT*WBITS | First stored setting of every ladder, ladder p in slice p |
| wr_en | input | 1 | Serial load strobe |
| wr_pot | input | PBITS | Ladder targeted by the serial load |
| wr_data | input | WBITS | Code for the serial load |
| xfer_en | input | 1 | Single transfer strobe |
| xfer_pot | input | PBITS | Ladder targeted by the single transfer |
| xfer_data | input | WBITS | Stored setting to copy into that ladder |
| gxfer_en | input | 1 | Global transfer strobe |
| gxfer_data | input | NPOT*WBITS | Stored setting for each ladder, ladder p in slice p |
| step_arm | input | 1 | Arms stepping mode |
| step_pot | input | PBITS | Ladder to step, latched when `step_arm` is high |
| sck | input | 1 | Serial clock line (asynchronous) |
| si | input | 1 | Serial data line (asynchronous); sets the step direction |
| cs_n | input | 1 | Chip select line, active low (asynchronous); its rise ends stepping |
| rd_pot | input | PBITS | Ladder selected for readback |
| rd_data | output | WBITS | Code of ladder `rd_pot` |
| wiper_pos | output | NPOT*WBITS | Codes of all ladders, ladder p in slice p |
| tap_sel | output | NPOT*NTAP | One-hot tap enables, ladder p in slice p |

## Verification
The bench pushes a ladder past 3Fh and below 00h by stepping. A counter that wraps would then jump to the opposite terminal, and the tap enables would follow it. It makes a serial load land on the same edge as a global transfer, and on the same edge as a step. A wrong priority order would leave the transfer value or the stepped value where the host's code belongs. It also sends `sck` pulses after `cs_n` has risen, and pulses with no stepping armed. A design that leaves the mode latched, or that steps without being armed, would move a ladder there. Pulses are timed against the resynchroniser latency, so one extra or one missing flop stage shows up as a code that changes one cycle early or one cycle late.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int unsigned POT_COUNT  = 4;
    localparam int unsigned POS_BITS   = 6;
    localparam int unsigned SYNC_DEPTH = 2;

    // Which source updates a position in a given cycle
    typedef enum logic [2:0] {
        LD_HOLD,
        LD_SERIAL,
        LD_GLOBAL,
        LD_SINGLE,
        LD_UP,
        LD_DOWN
    } load_src_e;

    // A step request produced by the stepping controller
    typedef struct packed {
        logic req;
        logic up;
    } step_req_t;

    // One saturating step within [0, top]
    function automatic logic [15:0] sat_step(logic [15:0] v, logic up, logic [15:0] top);
        if (up) begin
            return (v >= top) ? top : v + 16'd1;
        end
        return (v == 16'd0) ? 16'd0 : v - 16'd1;
    endfunction

endpackage

// File: rtl/wpr_sync_edge.sv
module wpr_sync_edge #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {DEPTH{IDLE}};
        end else begin
            chain <= {chain[DEPTH-2:0], din};
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/wpr_step_ctl.sv
module wpr_step_ctl
    import wpr_pkg::*;
#(
    parameter int unsigned PBITS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [PBITS-1:0] arm_pot,
    input  logic             end_rise,
    input  logic             sck_rise,
    input  logic             si_level,
    output logic [PBITS-1:0] sel_pot,
    output step_req_t        step
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            sel_pot <= '0;
        end else if (arm) begin
            armed   <= 1'b1;
            sel_pot <= arm_pot;
        end else if (end_rise) begin
            armed   <= 1'b0;
        end
    end

    assign step.req = armed & sck_rise;
    assign step.up  = si_level;
endmodule

// File: rtl/wpr_cell.sv
module wpr_cell
    import wpr_pkg::*;
#(
    parameter int unsigned WBITS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WBITS-1:0] recall_val,
    input  load_src_e        src,
    input  logic [WBITS-1:0] load_val,
    output logic [WBITS-1:0] pos,
    output logic [(1<<WBITS)-1:0] taps
);
    localparam int unsigned NTAP = 1 << WBITS;
    localparam logic [15:0] TOP  = 16'(NTAP - 1);

    logic [WBITS-1:0] nxt;

    always_comb begin
        case (src)
            LD_SERIAL, LD_GLOBAL, LD_SINGLE: nxt = load_val;
            LD_UP:   nxt = WBITS'(sat_step(16'(pos), 1'b1, TOP));
            LD_DOWN: nxt = WBITS'(sat_step(16'(pos), 1'b0, TOP));
            default: nxt = pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= recall_val;
        end else begin
            pos <= nxt;
        end
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign taps[t] = (pos == WBITS'(t));
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wpr_pkg::*;
#(
    parameter int unsigned NPOT        = POT_COUNT,
    parameter int unsigned WBITS       = POS_BITS,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH,
    localparam int unsigned PBITS      = (NPOT > 1) ? $clog2(NPOT) : 1,
    localparam int unsigned NTAP       = 1 << WBITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPOT*WBITS-1:0] nv_slot0,
    input  logic                  wr_en,
    input  logic [PBITS-1:0]      wr_pot,
    input  logic [WBITS-1:0]      wr_data,
    input  logic                  xfer_en,
    input  logic [PBITS-1:0]      xfer_pot,
    input  logic [WBITS-1:0]      xfer_data,
    input  logic                  gxfer_en,
    input  logic [NPOT*WBITS-1:0] gxfer_data,
    input  logic                  step_arm,
    input  logic [PBITS-1:0]      step_pot,
    input  logic                  sck,
    input  logic                  si,
    input  logic                  cs_n,
    input  logic [PBITS-1:0]      rd_pot,
    output logic [WBITS-1:0]      rd_data,
    output logic [NPOT*WBITS-1:0] wiper_pos,
    output logic [NPOT*NTAP-1:0]  tap_sel
);
    logic             sck_level, sck_rise;
    logic             si_level, si_rise;
    logic             cs_level, cs_rise;
    logic [PBITS-1:0] sel_pot;
    step_req_t        step;
    logic [WBITS-1:0] pos_arr [NPOT];

    wpr_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .din(sck), .level(sck_level), .rise(sck_rise)
    );
    wpr_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_si_sync (
        .clk(clk), .rst(rst), .din(si), .level(si_level), .rise(si_rise)
    );
    wpr_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .din(cs_n), .level(cs_level), .rise(cs_rise)
    );

    wpr_step_ctl #(.PBITS(PBITS)) u_step (
        .clk      (clk),
        .rst      (rst),
        .arm      (step_arm),
        .arm_pot  (step_pot),
        .end_rise (cs_rise),
        .sck_rise (sck_rise),
        .si_level (si_level),
        .sel_pot  (sel_pot),
        .step     (step)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        load_src_e        src;
        logic [WBITS-1:0] val;

        // Fixed priority: serial > global > single > step
        always_comb begin
            src = LD_HOLD;
            val = '0;
            if (wr_en && wr_pot == PBITS'(p)) begin
                src = LD_SERIAL;
                val = wr_data;
            end else if (gxfer_en) begin
                src = LD_GLOBAL;
                val = gxfer_data[p*WBITS +: WBITS];
            end else if (xfer_en && xfer_pot == PBITS'(p)) begin
                src = LD_SINGLE;
                val = xfer_data;
            end else if (step.req && sel_pot == PBITS'(p)) begin
                src = step.up ? LD_UP : LD_DOWN;
            end
        end

        wpr_cell #(.WBITS(WBITS)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .recall_val (nv_slot0[p*WBITS +: WBITS]),
            .src        (src),
            .load_val   (val),
            .pos        (pos_arr[p]),
            .taps       (tap_sel[p*NTAP +: NTAP])
        );

        assign wiper_pos[p*WBITS +: WBITS] = pos_arr[p];
    end

    assign rd_data = pos_arr[rd_pot];

    // Level and rise outputs that the block does not consume
    logic unused_sync;
    assign unused_sync = sck_level ^ si_rise ^ cs_level;
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
    parameter int unsigned NPOT  = 4,
    parameter int unsigned WBITS = 6,
    parameter int unsigned PBITS = 2,
    parameter int unsigned NTAP  = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [PBITS-1:0]      wr_pot,
    input logic [WBITS-1:0]      wr_data,
    input logic                  xfer_en,
    input logic [PBITS-1:0]      xfer_pot,
    input logic [WBITS-1:0]      xfer_data,
    input logic                  gxfer_en,
    input logic [NPOT*WBITS-1:0] gxfer_data,
    input logic [PBITS-1:0]      rd_pot,
    input logic [WBITS-1:0]      rd_data,
    input logic [NPOT*WBITS-1:0] wiper_pos,
    input logic [NPOT*NTAP-1:0]  tap_sel
);
    for (genvar p = 0; p < NPOT; p++) begin : g_chk
        // R2
        tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(tap_sel[p*NTAP +: NTAP]) == 1);

        // R2
        tap_match_chk: assert property (@(posedge clk) disable iff (rst)
            tap_sel[p*NTAP + int'(wiper_pos[p*WBITS +: WBITS])]);

        // R3
        serial_load_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_pot == PBITS'(p))
            |=> wiper_pos[p*WBITS +: WBITS] == $past(wr_data));

        // R5
        global_load_chk: assert property (@(posedge clk) disable iff (rst)
            (gxfer_en && !(wr_en && wr_pot == PBITS'(p)))
            |=> wiper_pos[p*WBITS +: WBITS] == $past(gxfer_data[p*WBITS +: WBITS]));

        // R4
        single_load_chk: assert property (@(posedge clk) disable iff (rst)
            (xfer_en && xfer_pot == PBITS'(p) && !gxfer_en && !(wr_en && wr_pot == PBITS'(p)))
            |=> wiper_pos[p*WBITS +: WBITS] == $past(xfer_data));
    end

    // R10
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data == wiper_pos[int'(rd_pot)*WBITS +: WBITS]);
endmodule

bind wiper_bank wiper_bank_chk #(
    .NPOT(NPOT), .WBITS(WBITS), .PBITS(PBITS), .NTAP(NTAP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_pot     (wr_pot),
    .wr_data    (wr_data),
    .xfer_en    (xfer_en),
    .xfer_pot   (xfer_pot),
    .xfer_data  (xfer_data),
    .gxfer_en   (gxfer_en),
    .gxfer_data (gxfer_data),
    .rd_pot     (rd_pot),
    .rd_data    (rd_data),
    .wiper_pos  (wiper_pos),
    .tap_sel    (tap_sel)
);

// File: tb/sim_wiper_bank.sv
`timescale 1ns/1ps
module sim_wiper_bank;
    localparam int NP = 4;
    localparam int WB = 6;
    localparam int NT = 64;
    localparam int SD = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP*WB-1:0] nv_slot0 = '0;
    logic            wr_en = 0, xfer_en = 0, gxfer_en = 0, step_arm = 0;
    logic [1:0]      wr_pot = 0, xfer_pot = 0, step_pot = 0, rd_pot = 0;
    logic [WB-1:0]   wr_data = 0, xfer_data = 0;
    logic [NP*WB-1:0] gxfer_data = '0;
    logic            sck = 0, si = 0, cs_n = 1;
    logic [WB-1:0]   rd_data;
    logic [NP*WB-1:0] wiper_pos;
    logic [NP*NT-1:0] tap_sel;

    always #2.5 clk = ~clk;

    wiper_bank u0 (
        .clk(clk), .rst(rst), .nv_slot0(nv_slot0),
        .wr_en(wr_en), .wr_pot(wr_pot), .wr_data(wr_data),
        .xfer_en(xfer_en), .xfer_pot(xfer_pot), .xfer_data(xfer_data),
        .gxfer_en(gxfer_en), .gxfer_data(gxfer_data),
        .step_arm(step_arm), .step_pot(step_pot),
        .sck(sck), .si(si), .cs_n(cs_n),
        .rd_pot(rd_pot), .rd_data(rd_data),
        .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    int    n_run = 0, n_fail = 0;
    string req = "R1";
    bit    started = 0, done = 0;

    // Behavioural reference model
    int m_pos [NP];
    bit m_arm;
    int m_sel;
    bit h_sck [$], h_si [$], h_cs [$];

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) m_pos[p] = int'(nv_slot0[p*WB +: WB]);
            m_arm = 0;
            m_sel = 0;
            h_sck = {}; h_si = {}; h_cs = {};
            for (int i = 0; i <= SD; i++) begin
                h_sck.push_back(1'b0); h_si.push_back(1'b0); h_cs.push_back(1'b1);
            end
        end else begin
            bit sck_r, si_l, cs_r, do_step;
            sck_r   = h_sck[SD-1] && !h_sck[SD];
            si_l    = h_si[SD-1];
            cs_r    = h_cs[SD-1] && !h_cs[SD];
            do_step = m_arm && sck_r;
            for (int p = 0; p < NP; p++) begin
                if (wr_en && int'(wr_pot) == p) m_pos[p] = int'(wr_data);
                else if (gxfer_en) m_pos[p] = int'(gxfer_data[p*WB +: WB]);
                else if (xfer_en && int'(xfer_pot) == p) m_pos[p] = int'(xfer_data);
                else if (do_step && m_sel == p) begin
                    if (si_l) m_pos[p] = (m_pos[p] >= NT-1) ? NT-1 : m_pos[p] + 1;
                    else      m_pos[p] = (m_pos[p] == 0) ? 0 : m_pos[p] - 1;
                end
            end
            if (step_arm) begin m_arm = 1; m_sel = int'(step_pot); end
            else if (cs_r) m_arm = 0;
            h_sck.push_front(sck); void'(h_sck.pop_back());
            h_si.push_front(si);   void'(h_si.pop_back());
            h_cs.push_front(cs_n); void'(h_cs.pop_back());
        end
        started = 1;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            bit bad;
            bad = 0;
            n_run++;
            for (int p = 0; p < NP; p++) begin
                logic [NT-1:0] exp_t;
                exp_t = '0;
                exp_t[m_pos[p]] = 1'b1;
                if (int'(wiper_pos[p*WB +: WB]) != m_pos[p]) begin
                    $display("FAIL %s pot%0d position actual=%0h expected=%0h",
                             req, p, wiper_pos[p*WB +: WB], m_pos[p]);
                    bad = 1;
                end
                if (tap_sel[p*NT +: NT] != exp_t) begin
                    $display("FAIL %s/R2 pot%0d taps actual=%h expected=%h",
                             req, p, tap_sel[p*NT +: NT], exp_t);
                    bad = 1;
                end
            end
            if (int'(rd_data) != m_pos[rd_pot]) begin
                $display("FAIL %s/R10 readback actual=%0h expected=%0h", req, rd_data, m_pos[rd_pot]);
                bad = 1;
            end
            if (bad) n_fail++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(bit dir);
        sck = 1; si = dir;
        tick(3);
        sck = 0;
        tick(3);
    endtask

    initial begin
        nv_slot0 = {6'h2A, 6'h00, 6'h3F, 6'h05};
        tick(3);
        rst = 0;
        req = "R1"; tick(3);
        req = "R2"; tick(2);

        req = "R3";
        for (int p = 0; p < NP; p++) begin
            wr_en = 1; wr_pot = 2'(p); wr_data = 6'(8'h11 + 8'(p*7));
            tick(1); wr_en = 0; tick(1);
        end

        req = "R4";
        for (int p = 0; p < NP; p++) begin
            xfer_en = 1; xfer_pot = 2'(p); xfer_data = 6'(6'h30 - 6'(p));
            tick(1); xfer_en = 0; tick(1);
        end

        req = "R5";
        gxfer_en = 1; gxfer_data = {6'h01, 6'h3E, 6'h20, 6'h0F};
        tick(1); gxfer_en = 0; tick(1);

        req = "R9";
        wr_en = 1; wr_pot = 1; wr_data = 6'h07;
        gxfer_en = 1; gxfer_data = {6'h33, 6'h22, 6'h11, 6'h00};
        tick(1); wr_en = 0; gxfer_en = 0; tick(1);
        gxfer_en = 1; xfer_en = 1; xfer_pot = 3; xfer_data = 6'h15;
        tick(1); gxfer_en = 0; tick(1);
        wr_en = 1; wr_pot = 3; wr_data = 6'h2B;
        tick(1); wr_en = 0; xfer_en = 0; tick(1);

        req = "R10";
        for (int r = 0; r < NP; r++) begin
            rd_pot = 2'(r); tick(1);
        end

        req = "R6";
        wr_en = 1; wr_pot = 2; wr_data = 6'h3D; tick(1); wr_en = 0;
        cs_n = 0; step_arm = 1; step_pot = 2; rd_pot = 2; tick(1); step_arm = 0;
        pulse(1); pulse(1);
        req = "R8";
        pulse(1); pulse(1);
        req = "R6";
        pulse(0); pulse(0); pulse(0);

        req = "R11";
        wr_en = 1; wr_pot = 0; wr_data = 6'h01; tick(1); wr_en = 0;
        step_arm = 1; step_pot = 0; rd_pot = 0; tick(1); step_arm = 0;
        pulse(0);
        req = "R8";
        pulse(0); pulse(0); pulse(1);

        req = "R7";
        cs_n = 1; tick(5);
        pulse(1); pulse(1); pulse(0);
        cs_n = 0; tick(4);
        pulse(1); pulse(0);
        cs_n = 1; tick(4);

        req = "R9";
        cs_n = 0; step_arm = 1; step_pot = 3; rd_pot = 3; tick(1); step_arm = 0;
        sck = 1; si = 1; tick(2);
        wr_en = 1; wr_pot = 3; wr_data = 6'h10; tick(1); wr_en = 0;
        sck = 0; tick(3);
        pulse(1);
        cs_n = 1; tick(4);

        req = "R1";
        nv_slot0 = {6'h0C, 6'h3F, 6'h00, 6'h19};
        rst = 1; tick(2); rst = 0; tick(4);
        pulse(1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule